// File: doc/BRIEF.md
# Banked Memory-Map Address Decoder

This block sits between the CPU bus of an 8-bit machine with a 16-bit address space and the memories and peripherals behind it. For each bus cycle it picks exactly one target: main RAM, the on-chip bank port, the BASIC ROM, the KERNAL ROM, the character ROM, the video chip, the sound chip, colour RAM, one of two peripheral interface chips, or the expansion I/O window. For the devices that are mirrored across a window, it also supplies the register offset.

The bank port is a pair of byte registers at addresses 0 and 1: a direction byte and a data byte. Three bits of the port decide whether the upper areas show ROM, I/O or plain RAM. A pin set as input reads as 1 for banking, as if pulled up. Reads of the port return the data byte on output pins and the external pin level on input pins. ROMs are visible only to reads, so a write always lands in the RAM underneath.

Top module: `retro_addr_decode`

## Requirements
- R1: After reset the direction byte (address 0x0000) reads 0xEF and the data byte (address 0x0001) reads 0x37.
- R2: A write to address 0 or 1 updates that byte at the clock edge. Reading address 1 returns, bit by bit, the data bit where the direction bit is 1 and `port_pin_in` where it is 0.
- R3: The effective bank bits are the data byte OR the inverted direction byte, taken on bit 0 (BASIC enable), bit 1 (KERNAL enable) and bit 2 (I/O enable). An input pin therefore counts as 1.
- R4: Addresses 0x0002–0x7FFF, 0x8000–0x9FFF and 0xC000–0xCFFF always select RAM.
- R5: A read in 0xA000–0xBFFF selects the BASIC ROM when bank bit 0 is 1. Otherwise it selects RAM.
- R6: A read in 0xE000–0xFFFF selects the KERNAL ROM when bank bit 1 is 1. Otherwise it selects RAM.
- R7: In 0xD000–0xDFFF, with bank bit 0 or bit 1 set, bank bit 2 = 1 maps the I/O devices. Bank bit 2 = 0 makes reads select the character ROM and writes select RAM.
- R8: With bank bits 0 and 1 both 0, every address above 0x0001 selects RAM, including 0xD000–0xDFFF.
- R9: A write never selects the BASIC, KERNAL or character ROM. It goes to RAM instead.
- R10: The video chip fills 0xD000–0xD3FF with a mirror every 64 bytes, and `reg_offset` = address bits 5:0. For offsets 0x2F–0x3F, reads raise `const_ff` (data reads 0xFF) and `dev_we` stays 0 on writes.
- R11: The sound chip fills 0xD400–0xD7FF with a mirror every 32 bytes, and the offset = address bits 4:0. Colour RAM fills 0xD800–0xDBFF, the offset = address bits 9:0, and a read raises `nib_only` (only the low data nibble is driven).
- R12: The first interface chip fills 0xDC00–0xDCFF and the second fills 0xDD00–0xDDFF, each with offset = address bits 3:0. Expansion I/O fills 0xDE00–0xDFFF with offset = address bits 8:0. For any target without a window, `reg_offset` is 0.
- R13: `cs` has exactly one bit set during a valid cycle and none otherwise. The bit order is: 0 RAM, 1 bank port, 2 BASIC, 3 KERNAL, 4 character ROM, 5 video, 6 sound, 7 colour RAM, 8 interface chip 1, 9 interface chip 2, 10 expansion I/O. `dev_we` is high only on valid writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus cycle in progress |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | Write data (used for the bank port) |
| port_pin_in | input | 8 | External levels of the bank port pins |
| cs | output | 11 | One-hot target select |
| reg_offset | output | 10 | Register offset within the selected window |
| dev_we | output | 1 | Write strobe to the selected target |
| const_ff | output | 1 | Read of an unused video register, data is 0xFF |
| nib_only | output | 1 | Colour RAM read, upper nibble undriven |
| port_rdata | output | 8 | Bank port read data, 0 when the port is not read |

## Verification
The bench builds the block with its default parameters: a 64-register video window with 47 live registers, a 32-byte sound mirror, 16-register interface chips and reset values 0xEF and 0x37. These defaults bring the whole map within reach. The bench sets the direction byte to all outputs and steps through all eight bank-bit combinations. For each one it reads and writes window edges, mirror images and the dead video range. It then sets port pins to input to show the pull-up rule and the mixed read-back.

// File: rtl/rad_pkg.sv
package rad_pkg;

  localparam int unsigned NUM_TGT = 11;

  typedef enum int unsigned {
    T_RAM    = 0,
    T_PORT   = 1,
    T_BASIC  = 2,
    T_KERNAL = 3,
    T_CHAR   = 4,
    T_VIDEO  = 5,
    T_SOUND  = 6,
    T_COLOR  = 7,
    T_PIA1   = 8,
    T_PIA2   = 9,
    T_EXPIO  = 10
  } tgt_e;

  // MSB first: loram is bit 2, hiram bit 1, charen bit 0
  typedef struct packed {
    logic loram;
    logic hiram;
    logic charen;
  } bank_t;

  // an input pin counts as pulled high
  function automatic bank_t bank_from_port(input logic [2:0] dir, input logic [2:0] dat);
    logic [2:0] eff;
    eff = dat | ~dir;
    return '{loram: eff[0], hiram: eff[1], charen: eff[2]};
  endfunction

  function automatic logic [7:0] port_mix(input logic [7:0] dir, input logic [7:0] dat,
                                          input logic [7:0] pins);
    return (dat & dir) | (pins & ~dir);
  endfunction

  // device inside the 0xD000 page, from address bits 11:8
  function automatic tgt_e io_target(input logic [3:0] page_lo);
    tgt_e t;
    case (page_lo[3:2])
      2'b00:   t = T_VIDEO;
      2'b01:   t = T_SOUND;
      2'b10:   t = T_COLOR;
      default: begin
        case (page_lo[1:0])
          2'b00:   t = T_PIA1;
          2'b01:   t = T_PIA2;
          default: t = T_EXPIO;
        endcase
      end
    endcase
    return t;
  endfunction

endpackage

// File: rtl/rad_bank_port.sv
module rad_bank_port
  import rad_pkg::*;
#(
  parameter logic [7:0] DIR_RST = 8'hEF,
  parameter logic [7:0] DAT_RST = 8'h37
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_dat,
  input  logic [7:0] wdata,
  input  logic [7:0] pin_in,
  input  logic       rd_dat,
  output logic [7:0] rd_byte,
  output bank_t      bank
);

  logic [7:0] dir_q;
  logic [7:0] dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= DIR_RST;
      dat_q <= DAT_RST;
    end else if (wr_en) begin
      if (wr_dat) dat_q <= wdata;
      else        dir_q <= wdata;
    end
  end

  assign rd_byte = rd_dat ? port_mix(dir_q, dat_q, pin_in) : dir_q;
  assign bank    = bank_from_port(dir_q[2:0], dat_q[2:0]);

endmodule

// File: rtl/rad_region_map.sv
module rad_region_map
  import rad_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic               valid,
  input  logic               rd,
  input  logic [AW-1:0]      addr,
  input  bank_t              bank,
  output logic [NUM_TGT-1:0] sel
);

  localparam logic [3:0] NIB_BASIC_LO = 4'hA;
  localparam logic [3:0] NIB_BASIC_HI = 4'hB;
  localparam logic [3:0] NIB_IO       = 4'hD;
  localparam logic [3:0] NIB_KERN_LO  = 4'hE;
  localparam logic [3:0] NIB_KERN_HI  = 4'hF;

  tgt_e tgt;
  logic rom_map_on;

  assign rom_map_on = bank.loram | bank.hiram;

  always_comb begin
    tgt = T_RAM;
    if (addr < AW'(2)) begin
      tgt = T_PORT;
    end else begin
      case (addr[AW-1 -: 4])
        NIB_BASIC_LO, NIB_BASIC_HI: if (rd && bank.loram) tgt = T_BASIC;
        NIB_KERN_LO,  NIB_KERN_HI:  if (rd && bank.hiram) tgt = T_KERNAL;
        NIB_IO: begin
          if (rom_map_on) begin
            if (bank.charen) tgt = io_target(addr[AW-5 -: 4]);
            else if (rd)     tgt = T_CHAR;
          end
        end
        default: tgt = T_RAM;
      endcase
    end
  end

  assign sel = valid ? (NUM_TGT'(1) << tgt) : '0;

endmodule

// File: rtl/rad_io_window.sv
module rad_io_window #(
  parameter int unsigned VID_REGS  = 64,
  parameter int unsigned VID_LIVE  = 47,
  parameter int unsigned SND_REGS  = 32,
  parameter int unsigned PIA_REGS  = 16,
  parameter int unsigned COL_DEPTH = 1024,
  parameter int unsigned EXP_SPAN  = 512,
  localparam int unsigned OFF_W    = $clog2(COL_DEPTH)
) (
  input  logic             valid,
  input  logic             rd,
  input  logic [OFF_W-1:0] addr_lo,
  input  logic             sel_video,
  input  logic             sel_sound,
  input  logic             sel_color,
  input  logic             sel_pia1,
  input  logic             sel_pia2,
  input  logic             sel_exp,
  output logic [OFF_W-1:0] reg_offset,
  output logic             vid_dead,
  output logic             dev_we,
  output logic             const_ff,
  output logic             nib_only
);

  localparam int unsigned VID_AW = $clog2(VID_REGS);
  localparam int unsigned SND_AW = $clog2(SND_REGS);
  localparam int unsigned PIA_AW = $clog2(PIA_REGS);
  localparam int unsigned EXP_AW = $clog2(EXP_SPAN);

  logic [OFF_W-1:0] off_vid, off_snd, off_pia, off_exp;

  assign off_vid = OFF_W'(addr_lo[VID_AW-1:0]);
  assign off_snd = OFF_W'(addr_lo[SND_AW-1:0]);
  assign off_pia = OFF_W'(addr_lo[PIA_AW-1:0]);
  assign off_exp = OFF_W'(addr_lo[EXP_AW-1:0]);

  always_comb begin
    reg_offset = '0;
    if (sel_video)             reg_offset = off_vid;
    if (sel_sound)             reg_offset = off_snd;
    if (sel_color)             reg_offset = addr_lo;
    if (sel_pia1 || sel_pia2)  reg_offset = off_pia;
    if (sel_exp)               reg_offset = off_exp;
  end

  assign vid_dead = sel_video && (off_vid >= OFF_W'(VID_LIVE));
  assign dev_we   = valid && !rd && !vid_dead;
  assign const_ff = rd && vid_dead;
  assign nib_only = rd && sel_color;

endmodule

// File: rtl/retro_addr_decode.sv
module retro_addr_decode
  import rad_pkg::*;
#(
  parameter logic [7:0]  DIR_RST   = 8'hEF,
  parameter logic [7:0]  DAT_RST   = 8'h37,
  parameter int unsigned VID_REGS  = 64,
  parameter int unsigned VID_LIVE  = 47,
  parameter int unsigned SND_REGS  = 32,
  parameter int unsigned PIA_REGS  = 16,
  parameter int unsigned COL_DEPTH = 1024,
  parameter int unsigned EXP_SPAN  = 512,
  localparam int unsigned AW       = 16,
  localparam int unsigned OFF_W    = $clog2(COL_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               cpu_rw,
  input  logic [AW-1:0]      cpu_addr,
  input  logic [7:0]         cpu_wdata,
  input  logic [7:0]         port_pin_in,
  output logic [NUM_TGT-1:0] cs,
  output logic [OFF_W-1:0]   reg_offset,
  output logic               dev_we,
  output logic               const_ff,
  output logic               nib_only,
  output logic [7:0]         port_rdata
);

  // named internal events, watched by the bound checker
  bank_t      bank_eff;
  logic       port_wr;
  logic       port_rd;
  logic       vid_dead;
  logic [7:0] port_byte;

  assign port_wr = bus_valid && !cpu_rw && cs[T_PORT];
  assign port_rd = bus_valid &&  cpu_rw && cs[T_PORT];

  rad_bank_port #(
    .DIR_RST (DIR_RST),
    .DAT_RST (DAT_RST)
  ) u_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (port_wr),
    .wr_dat  (cpu_addr[0]),
    .wdata   (cpu_wdata),
    .pin_in  (port_pin_in),
    .rd_dat  (cpu_addr[0]),
    .rd_byte (port_byte),
    .bank    (bank_eff)
  );

  rad_region_map #(
    .AW (AW)
  ) u_map (
    .valid (bus_valid),
    .rd    (cpu_rw),
    .addr  (cpu_addr),
    .bank  (bank_eff),
    .sel   (cs)
  );

  rad_io_window #(
    .VID_REGS  (VID_REGS),
    .VID_LIVE  (VID_LIVE),
    .SND_REGS  (SND_REGS),
    .PIA_REGS  (PIA_REGS),
    .COL_DEPTH (COL_DEPTH),
    .EXP_SPAN  (EXP_SPAN)
  ) u_win (
    .valid      (bus_valid),
    .rd         (cpu_rw),
    .addr_lo    (cpu_addr[OFF_W-1:0]),
    .sel_video  (cs[T_VIDEO]),
    .sel_sound  (cs[T_SOUND]),
    .sel_color  (cs[T_COLOR]),
    .sel_pia1   (cs[T_PIA1]),
    .sel_pia2   (cs[T_PIA2]),
    .sel_exp    (cs[T_EXPIO]),
    .reg_offset (reg_offset),
    .vid_dead   (vid_dead),
    .dev_we     (dev_we),
    .const_ff   (const_ff),
    .nib_only   (nib_only)
  );

  assign port_rdata = port_rd ? port_byte : 8'h00;

endmodule

// File: rtl/rad_checker.sv
module rad_checker
  import rad_pkg::*;
#(
  parameter int unsigned VID_LIVE = 47,
  parameter int unsigned OFF_W    = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_valid,
  input logic               cpu_rw,
  input logic [15:0]        cpu_addr,
  input logic [NUM_TGT-1:0] cs,
  input logic [OFF_W-1:0]   reg_offset,
  input logic               dev_we,
  input logic [2:0]         bank_eff,
  input logic               port_wr
);

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> $countones(cs) == 1); // R13

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (cs == '0 && !dev_we)); // R13

  AST_WRITE_SKIPS_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !cpu_rw) |-> !(cs[T_BASIC] || cs[T_KERNAL] || cs[T_CHAR])); // R9

  AST_LOW_HALF_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && cpu_addr > 16'h0001 && cpu_addr < 16'h8000) |-> cs[T_RAM]); // R4

  AST_ALL_RAM_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bank_eff[2:1] == 2'b00 && cpu_addr > 16'h0001) |-> cs[T_RAM]); // R8

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !port_wr |=> $stable(bank_eff)); // R3

  AST_DEAD_VIDEO_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs[T_VIDEO] && reg_offset >= OFF_W'(VID_LIVE)) |-> !dev_we); // R10

  AST_PIA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs[T_PIA1] || cs[T_PIA2]) |-> reg_offset == OFF_W'(cpu_addr[3:0])); // R12

endmodule

bind retro_addr_decode rad_checker #(
  .VID_LIVE (VID_LIVE),
  .OFF_W    (OFF_W)
) u_rad_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_valid  (bus_valid),
  .cpu_rw     (cpu_rw),
  .cpu_addr   (cpu_addr),
  .cs         (cs),
  .reg_offset (reg_offset),
  .dev_we     (dev_we),
  .bank_eff   (bank_eff),
  .port_wr    (port_wr)
);

// File: tb/test_retro_addr_decode.sv
`timescale 1ns/1ps
module test_retro_addr_decode;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid;
  logic        cpu_rw;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic [7:0]  port_pin_in;
  logic [10:0] cs;
  logic [9:0]  reg_offset;
  logic        dev_we, const_ff, nib_only;
  logic [7:0]  port_rdata;

  always #2.5 clk = ~clk;

  retro_addr_decode i_retro_addr_decode (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .cpu_rw(cpu_rw),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .port_pin_in(port_pin_in),
    .cs(cs), .reg_offset(reg_offset), .dev_we(dev_we), .const_ff(const_ff),
    .nib_only(nib_only), .port_rdata(port_rdata)
  );

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference state of the bank port
  int m_dir = 'hEF;
  int m_dat = 'h37;

  int probes[$] = '{'h0000, 'h0001, 'h0002, 'h7FFF, 'h8000, 'h9FFF, 'hA000, 'hBFFF,
                    'hC000, 'hCFFF, 'hD000, 'hD02E, 'hD02F, 'hD07F, 'hD3C5, 'hD400,
                    'hD7FF, 'hD800, 'hDBFF, 'hDC00, 'hDCFF, 'hDD13, 'hDE00, 'hDFFF,
                    'hE000, 'hFFFF};

  task automatic check(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // one bus cycle: drive at falling edge, compare mid-cycle, update model after rising edge
  task automatic step(bit valid, bit rd, int a, int wd, string tag);
    int eff, lo, hi, ch, tgt, off, pr;
    bit dead;
    string req;
    @(negedge clk);
    bus_valid = valid; cpu_rw = rd; cpu_addr = a[15:0]; cpu_wdata = wd[7:0];
    #1;
    eff = (m_dat | ~m_dir) & 7;
    lo = eff & 1; hi = (eff >> 1) & 1; ch = (eff >> 2) & 1;
    tgt = 0; off = 0; req = "R4";
    if (a <= 1) begin
      tgt = 1; req = "R2";
    end else if (a >= 'hA000 && a <= 'hBFFF) begin
      req = rd ? "R5" : "R9";
      if (rd && lo == 1) tgt = 2;
    end else if (a >= 'hE000) begin
      req = rd ? "R6" : "R9";
      if (rd && hi == 1) tgt = 3;
    end else if (a >= 'hD000 && a <= 'hDFFF) begin
      req = "R7";
      if (lo == 0 && hi == 0) req = "R8";
      else if (ch == 0) begin
        if (rd) tgt = 4; else req = "R9";
      end else if (a < 'hD400) begin tgt = 5; off = a % 64;  req = "R10"; end
      else if (a < 'hD800)     begin tgt = 6; off = a % 32;  req = "R11"; end
      else if (a < 'hDC00)     begin tgt = 7; off = a % 1024; req = "R11"; end
      else if (a < 'hDD00)     begin tgt = 8; off = a % 16;  req = "R12"; end
      else if (a < 'hDE00)     begin tgt = 9; off = a % 16;  req = "R12"; end
      else                     begin tgt = 10; off = a % 512; req = "R12"; end
    end
    if (!valid) req = "R13";
    if (tag != "") req = tag;
    dead = valid && tgt == 5 && off >= 'h2F;
    pr = 0;
    if (valid && rd && a == 0) pr = m_dir;
    if (valid && rd && a == 1) pr = ((m_dat & m_dir) | (port_pin_in & ~m_dir)) & 'hFF;
    check(req, $sformatf("cs @%04h", a), int'(cs), valid ? (1 << tgt) : 0);
    check(req, $sformatf("reg_offset @%04h", a), int'(reg_offset), valid ? off : 0);
    check(req, $sformatf("dev_we @%04h", a), int'(dev_we), (valid && !rd && !dead) ? 1 : 0);
    check(req, $sformatf("const_ff @%04h", a), int'(const_ff), (rd && dead) ? 1 : 0);
    check(req, $sformatf("nib_only @%04h", a), int'(nib_only), (valid && rd && tgt == 7) ? 1 : 0);
    check(req, $sformatf("port_rdata @%04h", a), int'(port_rdata), pr);
    @(posedge clk);
    if (valid && !rd && a == 0) m_dir = wd & 'hFF;
    if (valid && !rd && a == 1) m_dat = wd & 'hFF;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; cpu_rw = 1'b1; cpu_addr = '0;
    cpu_wdata = '0; port_pin_in = 8'b1101_0010;
    repeat (3) @(posedge clk);
    step(0, 1, 'hA000, 0, "R13");
    @(negedge clk); rst_n = 1'b1;
    // R1: reset values read back
    step(1, 1, 'h0000, 0, "R1");
    step(1, 1, 'h0001, 0, "R1");
    // default map (bank bits all 1)
    foreach (probes[i]) step(1, 1, probes[i], 0, "");
    step(0, 1, 'hD000, 0, "R13");
    // all outputs, sweep the eight bank combinations
    step(1, 0, 'h0000, 'hFF, "R2");
    for (int combo = 0; combo < 8; combo++) begin
      step(1, 0, 'h0001, 'h30 | combo, "R2");
      step(1, 1, 'h0001, 0, "R2");
      foreach (probes[i]) begin
        step(1, 1, probes[i], 0, "");
        if (probes[i] > 1) step(1, 0, probes[i], 'h5A, "");
      end
    end
    // R3: input pins count as 1 whatever the data byte holds
    step(1, 0, 'h0001, 'h30, "R3");
    step(1, 0, 'h0000, 'hF8, "R3");
    step(1, 1, 'hA000, 0, "R3");
    step(1, 1, 'hE000, 0, "R3");
    step(1, 1, 'hD800, 0, "R3");
    step(1, 1, 'h0001, 0, "R2");
    step(1, 0, 'h0000, 'hFA, "R3");
    step(1, 1, 'hE123, 0, "R3");
    step(1, 1, 'hB000, 0, "R3");
    step(1, 1, 'h0001, 0, "R2");
    step(0, 0, 'h0001, 'h00, "R13");
    step(1, 1, 'h0001, 0, "R13");
    done = 1;
    summary();
    $finish;
  end

endmodule